// File: doc/BRIEF.md
# Dual-Channel Disk I/O Decoder

This block sits between a host I/O port and a two-channel disk controller. Each host access is matched against five address windows: a command window and a control window for each of the two channels, plus one bus-master window that both channels share. A hit in a command or control window is forwarded to the currently selected drive (master or slave) of that channel. A hit in the bus-master window is forwarded to the register file of the channel that owns that part of the window. Window bases and sizes come in as inputs. Drive presence also comes in as an input.

The block keeps one drive-select bit per channel. A write to a fixed command offset updates that bit. The block applies two gates taken from the host command word: an I/O-enable gate for every access, and a bus-master-enable gate for writes to the bus-master window. Each request gets a response one cycle later. The response carries the read data or zero, and a decode-error flag for accesses the block cannot place.

Top module: `diskio_decoder`

## Requirements
- R1: When hostCmd bit 0 (I/O enable) is 0, a request forwards nothing, leaves drvSelect unchanged, and its response has rspRdata = 0 and rspDecErr = 0.
- R2: When hostCmd bit 2 (bus-master enable) is 0, writes that hit the bus-master window are dropped (bmValid stays 0). Reads of the same window are still forwarded.
- R3: A write that resolves to command offset 6 of a channel sets that channel's drvSelect bit to bit 4 of reqWdata (1 = slave, 0 = master). The new value takes effect for the forwarded write itself. drvSelect bit 0 is the primary channel and bit 1 the secondary.
- R4: After reset, drvSelect is 2'b00 (master on both channels) and rspValid is 0.
- R5: If drivePresent[{channel, slave}] is 0 for the selected drive, command and control accesses are not forwarded, and reads return 0 without a decode error.
- R6: Bus-master offsets 0 to 7 go to channel 0 and offsets 8 to 15 go to channel 1. In both cases bmOffset carries the low three bits. Offsets of 16 and above give a decode error.
- R7: Only reqSize values of 1, 2 and 4 are legal. Any other value gives a decode error and forwards nothing.
- R8: A primary command offset is shifted right by PRI_CMD_SHIFT, and PRI_CTRL_ADD is added to a primary control offset. Secondary offsets pass through unchanged.
- R9: An access that hits no window gives rspDecErr = 1 and rspRdata = 0.
- R10: Overlapping windows resolve in a fixed order: primary command, then primary control, then secondary command, then secondary control, then bus-master. At most one of drvValid and bmValid is high at a time.
- R11: Forwarding strobes are combinational in the request cycle. The response (rspValid, rspRdata, rspDecErr) appears in the cycle after the request. Read data is taken from the forwarded target in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostCmd | input | 16 | Host command word; bit 0 I/O enable, bit 2 bus-master enable |
| winBase | input | 5×AW | Window bases, index 0..4 = pri cmd, pri ctrl, sec cmd, sec ctrl, bus-master |
| winSize | input | 5×AW | Window sizes in bytes, same indexing; 0 disables a window |
| drivePresent | input | 4 | Drive present, index {channel, slave} |
| reqValid | input | 1 | Host access request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | AW | Access address |
| reqSize | input | 3 | Access size in bytes |
| reqWdata | input | DW | Write data |
| drvValid | output | 1 | Forward to a drive |
| drvWrite | output | 1 | Forwarded direction |
| drvChannel | output | 1 | Target channel |
| drvSlave | output | 1 | Target drive, 1 = slave |
| drvIsCtrl | output | 1 | 1 = control register block, 0 = command block |
| drvOffset | output | AW | Adjusted register offset |
| drvSize | output | 3 | Forwarded size |
| drvWdata | output | DW | Forwarded write data |
| drvRdata | input | DW | Drive read data for the current forward |
| bmValid | output | 1 | Forward to a bus-master register file |
| bmWrite | output | 1 | Forwarded direction |
| bmChannel | output | 1 | Owning channel |
| bmOffset | output | log2(BM_SPAN) | Offset within the channel's registers |
| bmSize | output | 3 | Forwarded size |
| bmWdata | output | DW | Forwarded write data |
| bmRdata | input | DW | Bus-master read data for the current forward |
| rspValid | output | 1 | Response for the previous cycle's request |
| rspDecErr | output | 1 | Decode error |
| rspRdata | output | DW | Read data, zero when nothing was read |
| drvSelect | output | 2 | Per-channel drive-select state |

## Verification
The checker watches several rules on every cycle:
- nothing is forwarded while I/O is disabled;
- no bus-master write gets out while bus mastering is off;
- a forward never targets an absent drive;
- the two forward strobes never fire together;
- only legal sizes are forwarded;
- the select state changes only after an enabled write;
- every response follows a request, and an error response carries zero data.

Only the bench scenarios can show the correct values:
- the offset arithmetic on the primary windows;
- which window wins where windows overlap;
- the channel split of the bus-master window;
- that the select write reaches the newly chosen drive;
- that read data from the stubs is returned one cycle later.

// File: rtl/diskio_pkg.sv
package diskio_pkg;
  localparam int NUM_WIN    = 5;
  localparam int IO_EN_BIT  = 0;
  localparam int BM_EN_BIT  = 2;
  localparam int SEL_OFFSET = 6;
  localparam int SEL_BIT    = 4;

  // Index order is also match priority (lowest index wins)
  typedef enum logic [2:0] {
    WIN_PCMD = 3'd0,
    WIN_PCTL = 3'd1,
    WIN_SCMD = 3'd2,
    WIN_SCTL = 3'd3,
    WIN_BM   = 3'd4,
    WIN_NONE = 3'd7
  } winSel_e;

  typedef struct packed {
    logic    fwdDrv;
    logic    fwdBm;
    logic    selLoad;
    logic    rspLoad;
    logic    decErr;
    logic    useDrvData;
    logic    useBmData;
    logic    chan;
    logic    slave;
    logic    isCtrl;
    winSel_e win;
  } strobe_t;
endpackage

// File: rtl/diskio_ctrl.sv
module diskio_ctrl
  import diskio_pkg::*;
(
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [2:0]         reqSize,
  input  logic               ioEn,
  input  logic               bmEn,
  input  logic [NUM_WIN-1:0] winHit,
  input  logic               priSelHit,
  input  logic               secSelHit,
  input  logic               bmInRange,
  input  logic               bmUpper,
  input  logic [1:0]         selReg,
  input  logic               selData,
  input  logic [3:0]         drivePresent,
  output strobe_t            stb
);
  winSel_e pick;
  logic    sizeOk;
  logic    isSec;
  logic    isCmd;
  logic    effSel;
  logic    present;

  always_comb begin
    pick = WIN_NONE;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (winHit[i]) pick = winSel_e'(3'(i));
    end
  end

  assign sizeOk = (reqSize == 3'd1) || (reqSize == 3'd2) || (reqSize == 3'd4);
  assign isSec  = (pick == WIN_SCMD) || (pick == WIN_SCTL);
  assign isCmd  = (pick == WIN_PCMD) || (pick == WIN_SCMD);

  always_comb begin
    stb     = '0;
    stb.win = WIN_NONE;
    effSel  = 1'b0;
    present = 1'b0;
    if (reqValid) begin
      stb.rspLoad = 1'b1;
      if (!ioEn) begin
        stb.rspLoad = 1'b1;
      end else if (!sizeOk) begin
        stb.decErr = 1'b1;
      end else begin
        stb.win = pick;
        case (pick)
          WIN_PCMD, WIN_PCTL, WIN_SCMD, WIN_SCTL: begin
            stb.chan    = isSec;
            stb.isCtrl  = !isCmd;
            stb.selLoad = reqWrite && isCmd && (isSec ? secSelHit : priSelHit);
            effSel      = stb.selLoad ? selData : selReg[isSec];
            stb.slave   = effSel;
            present     = drivePresent[{isSec, effSel}];
            stb.fwdDrv     = present;
            stb.useDrvData = present && !reqWrite;
          end
          WIN_BM: begin
            if (!bmInRange) begin
              stb.decErr = 1'b1;
            end else begin
              stb.chan = bmUpper;
              if (!(reqWrite && !bmEn)) begin
                stb.fwdBm     = 1'b1;
                stb.useBmData = !reqWrite;
              end
            end
          end
          default: stb.decErr = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/diskio_datapath.sv
module diskio_datapath
  import diskio_pkg::*;
#(
  parameter int AW            = 16,
  parameter int DW            = 32,
  parameter int PRI_CMD_SHIFT = 1,
  parameter int PRI_CTRL_ADD  = 2,
  parameter int BM_SPAN       = 8,
  localparam int BM_OFF_W     = $clog2(BM_SPAN)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqWrite,
  input  logic [AW-1:0]               reqAddr,
  input  logic [2:0]                  reqSize,
  input  logic [DW-1:0]               reqWdata,
  input  logic [NUM_WIN-1:0][AW-1:0]  winBase,
  input  logic [NUM_WIN-1:0][AW-1:0]  winSize,
  input  logic [DW-1:0]               drvRdata,
  input  logic [DW-1:0]               bmRdata,
  input  strobe_t                     stb,
  output logic [NUM_WIN-1:0]          winHit,
  output logic                        priSelHit,
  output logic                        secSelHit,
  output logic                        bmInRange,
  output logic                        bmUpper,
  output logic [1:0]                  selReg,
  output logic                        drvValid,
  output logic                        drvWrite,
  output logic                        drvChannel,
  output logic                        drvSlave,
  output logic                        drvIsCtrl,
  output logic [AW-1:0]               drvOffset,
  output logic [2:0]                  drvSize,
  output logic [DW-1:0]               drvWdata,
  output logic                        bmValid,
  output logic                        bmWrite,
  output logic                        bmChannel,
  output logic [BM_OFF_W-1:0]         bmOffset,
  output logic [2:0]                  bmSize,
  output logic [DW-1:0]               bmWdata,
  output logic                        rspValid,
  output logic                        rspDecErr,
  output logic [DW-1:0]               rspRdata
);
  logic [NUM_WIN-1:0][AW-1:0] winOff;
  logic [AW-1:0] priCmdOff;
  logic [AW-1:0] priCtlOff;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign winOff[w] = reqAddr - winBase[w];
    assign winHit[w] = (reqAddr >= winBase[w]) && (winOff[w] < winSize[w]);
  end

  assign priCmdOff = winOff[WIN_PCMD] >> PRI_CMD_SHIFT;
  assign priCtlOff = winOff[WIN_PCTL] + AW'(PRI_CTRL_ADD);
  assign priSelHit = (priCmdOff == AW'(SEL_OFFSET));
  assign secSelHit = (winOff[WIN_SCMD] == AW'(SEL_OFFSET));
  assign bmInRange = (winOff[WIN_BM] < AW'(2 * BM_SPAN));
  assign bmUpper   = winOff[WIN_BM][BM_OFF_W];

  always_comb begin
    case (stb.win)
      WIN_PCMD: drvOffset = priCmdOff;
      WIN_PCTL: drvOffset = priCtlOff;
      WIN_SCMD: drvOffset = winOff[WIN_SCMD];
      WIN_SCTL: drvOffset = winOff[WIN_SCTL];
      default:  drvOffset = '0;
    endcase
  end

  assign drvValid   = stb.fwdDrv;
  assign drvWrite   = reqWrite;
  assign drvChannel = stb.chan;
  assign drvSlave   = stb.slave;
  assign drvIsCtrl  = stb.isCtrl;
  assign drvSize    = reqSize;
  assign drvWdata   = reqWdata;

  assign bmValid   = stb.fwdBm;
  assign bmWrite   = reqWrite;
  assign bmChannel = stb.chan;
  assign bmOffset  = winOff[WIN_BM][BM_OFF_W-1:0];
  assign bmSize    = reqSize;
  assign bmWdata   = reqWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg <= 2'b00;
    end else if (stb.selLoad) begin
      selReg[stb.chan] <= reqWdata[SEL_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspDecErr <= 1'b0;
      rspRdata  <= '0;
    end else begin
      rspValid  <= stb.rspLoad;
      rspDecErr <= stb.decErr;
      if (stb.useDrvData)     rspRdata <= drvRdata;
      else if (stb.useBmData) rspRdata <= bmRdata;
      else                    rspRdata <= '0;
    end
  end
endmodule

// File: rtl/diskio_decoder.sv
module diskio_decoder
  import diskio_pkg::*;
#(
  parameter int AW            = 16,
  parameter int DW            = 32,
  parameter int PRI_CMD_SHIFT = 1,
  parameter int PRI_CTRL_ADD  = 2,
  parameter int BM_SPAN       = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [15:0]                      hostCmd,
  input  logic [NUM_WIN-1:0][AW-1:0]       winBase,
  input  logic [NUM_WIN-1:0][AW-1:0]       winSize,
  input  logic [3:0]                       drivePresent,
  input  logic                             reqValid,
  input  logic                             reqWrite,
  input  logic [AW-1:0]                    reqAddr,
  input  logic [2:0]                       reqSize,
  input  logic [DW-1:0]                    reqWdata,
  output logic                             drvValid,
  output logic                             drvWrite,
  output logic                             drvChannel,
  output logic                             drvSlave,
  output logic                             drvIsCtrl,
  output logic [AW-1:0]                    drvOffset,
  output logic [2:0]                       drvSize,
  output logic [DW-1:0]                    drvWdata,
  input  logic [DW-1:0]                    drvRdata,
  output logic                             bmValid,
  output logic                             bmWrite,
  output logic                             bmChannel,
  output logic [$clog2(BM_SPAN)-1:0]       bmOffset,
  output logic [2:0]                       bmSize,
  output logic [DW-1:0]                    bmWdata,
  input  logic [DW-1:0]                    bmRdata,
  output logic                             rspValid,
  output logic                             rspDecErr,
  output logic [DW-1:0]                    rspRdata,
  output logic [1:0]                       drvSelect
);
  strobe_t            stb;
  logic [NUM_WIN-1:0] winHit;
  logic               priSelHit;
  logic               secSelHit;
  logic               bmInRange;
  logic               bmUpper;

  diskio_ctrl u_ctrl (
    .reqValid     (reqValid),
    .reqWrite     (reqWrite),
    .reqSize      (reqSize),
    .ioEn         (hostCmd[IO_EN_BIT]),
    .bmEn         (hostCmd[BM_EN_BIT]),
    .winHit       (winHit),
    .priSelHit    (priSelHit),
    .secSelHit    (secSelHit),
    .bmInRange    (bmInRange),
    .bmUpper      (bmUpper),
    .selReg       (drvSelect),
    .selData      (reqWdata[SEL_BIT]),
    .drivePresent (drivePresent),
    .stb          (stb)
  );

  diskio_datapath #(
    .AW(AW), .DW(DW), .PRI_CMD_SHIFT(PRI_CMD_SHIFT),
    .PRI_CTRL_ADD(PRI_CTRL_ADD), .BM_SPAN(BM_SPAN)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .reqWrite   (reqWrite),
    .reqAddr    (reqAddr),
    .reqSize    (reqSize),
    .reqWdata   (reqWdata),
    .winBase    (winBase),
    .winSize    (winSize),
    .drvRdata   (drvRdata),
    .bmRdata    (bmRdata),
    .stb        (stb),
    .winHit     (winHit),
    .priSelHit  (priSelHit),
    .secSelHit  (secSelHit),
    .bmInRange  (bmInRange),
    .bmUpper    (bmUpper),
    .selReg     (drvSelect),
    .drvValid   (drvValid),
    .drvWrite   (drvWrite),
    .drvChannel (drvChannel),
    .drvSlave   (drvSlave),
    .drvIsCtrl  (drvIsCtrl),
    .drvOffset  (drvOffset),
    .drvSize    (drvSize),
    .drvWdata   (drvWdata),
    .bmValid    (bmValid),
    .bmWrite    (bmWrite),
    .bmChannel  (bmChannel),
    .bmOffset   (bmOffset),
    .bmSize     (bmSize),
    .bmWdata    (bmWdata),
    .rspValid   (rspValid),
    .rspDecErr  (rspDecErr),
    .rspRdata   (rspRdata)
  );
endmodule

// File: rtl/diskio_decoder_chk.sv
module diskio_decoder_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic [15:0]   hostCmd,
  input logic [3:0]    drivePresent,
  input logic          reqValid,
  input logic          reqWrite,
  input logic [2:0]    reqSize,
  input logic          drvValid,
  input logic          drvChannel,
  input logic          drvSlave,
  input logic          bmValid,
  input logic          bmWrite,
  input logic          rspValid,
  input logic          rspDecErr,
  input logic [DW-1:0] rspRdata,
  input logic [1:0]    drvSelect
);
  AST_IO_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !hostCmd[0] |-> !(drvValid || bmValid)); // R1
  AST_BM_WRITE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (bmValid && bmWrite) |-> hostCmd[2]); // R2
  AST_SEL_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (drvSelect != $past(drvSelect)) |-> $past(reqValid && reqWrite && hostCmd[0])); // R3
  AST_DRIVE_PRESENT: assert property (@(posedge clk) disable iff (!rstN)
    drvValid |-> drivePresent[{drvChannel, drvSlave}]); // R5
  AST_LEGAL_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    (drvValid || bmValid) |-> (reqSize == 3'd1 || reqSize == 3'd2 || reqSize == 3'd4)); // R7
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspDecErr) |-> (rspRdata == '0)); // R9
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({drvValid, bmValid})); // R10
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R11
  AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid)); // R11
endmodule

bind diskio_decoder diskio_decoder_chk #(.DW(DW)) u_chk (.*);

// File: tb/diskio_decoder_bench.sv
`timescale 1ns/1ps
module diskio_decoder_bench;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int SHIFT = 1;
  localparam int CADD = 2;

  logic clk = 0;
  logic rstN = 0;
  logic [15:0] hostCmd = 16'h0000;
  logic [4:0][AW-1:0] winBase;
  logic [4:0][AW-1:0] winSize;
  logic [3:0] drivePresent = 4'b0111;
  logic reqValid = 0, reqWrite = 0;
  logic [AW-1:0] reqAddr = '0;
  logic [2:0] reqSize = 3'd1;
  logic [DW-1:0] reqWdata = '0;
  logic drvValid, drvWrite, drvChannel, drvSlave, drvIsCtrl;
  logic [AW-1:0] drvOffset;
  logic [2:0] drvSize, bmSize;
  logic [DW-1:0] drvWdata, drvRdata, bmWdata, bmRdata, rspRdata;
  logic bmValid, bmWrite, bmChannel, rspValid, rspDecErr;
  logic [2:0] bmOffset;
  logic [1:0] drvSelect;

  int errors = 0, checks = 0;
  int selM[2] = '{0, 0};

  always #4 clk = ~clk;

  // Stubs: read data encodes the target so routing is visible in the response
  assign drvRdata = 32'hD000_0000 | (DW'({drvChannel, drvSlave, drvIsCtrl}) << 16) | DW'(drvOffset);
  assign bmRdata  = 32'hB000_0000 | (DW'(bmChannel) << 8) | DW'(bmOffset);

  diskio_decoder #(.AW(AW), .DW(DW), .PRI_CMD_SHIFT(SHIFT), .PRI_CTRL_ADD(CADD), .BM_SPAN(8))
    u_diskio_decoder (.*);

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic access(input string tag, input bit wr, input int addr,
                        input int size, input logic [31:0] wdata);
    int win = -1;
    bit eDrv = 0, eBm = 0, eErr = 0, eCh = 0, eSl = 0, eCtl = 0;
    int eOff = 0, eBmOff = 0, off = 0;
    logic [31:0] eRd = 0;
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = AW'(addr); reqSize = 3'(size); reqWdata = wdata;
    if (hostCmd[0]) begin
      if (!(size == 1 || size == 2 || size == 4)) eErr = 1;
      else begin
        for (int w = 4; w >= 0; w--)
          if (addr >= int'(winBase[w]) && addr < int'(winBase[w]) + int'(winSize[w])) win = w;
        if (win < 0) eErr = 1;
        else begin
          off = addr - int'(winBase[win]);
          if (win == 4) begin
            if (off >= 16) eErr = 1;
            else begin
              eCh = off >= 8; eBmOff = off % 8;
              if (!(wr && !hostCmd[2])) begin
                eBm = 1;
                if (!wr) eRd = 32'hB000_0000 | (32'(eCh) << 8) | 32'(eBmOff);
              end
            end
          end else begin
            eCh = (win >= 2); eCtl = (win == 1 || win == 3);
            eOff = (win == 0) ? (off >> SHIFT) : (win == 1) ? off + CADD : off;
            if (wr && !eCtl && eOff == 6) selM[eCh] = wdata[4];
            eSl = selM[eCh][0];
            if (drivePresent[{eCh, eSl}]) begin
              eDrv = 1;
              if (!wr) eRd = 32'hD000_0000 | (32'({eCh, eSl, eCtl}) << 16) | 32'(eOff);
            end
          end
        end
      end
    end
    #1;
    check(drvValid == eDrv, tag, "drvValid", 32'(drvValid), 32'(eDrv));
    check(bmValid == eBm, tag, "bmValid", 32'(bmValid), 32'(eBm));
    if (eDrv) check({drvChannel, drvSlave, drvIsCtrl} == {eCh, eSl, eCtl} && drvOffset == AW'(eOff),
                    tag, "drive route", {drvChannel, drvSlave, drvIsCtrl, 13'd0, drvOffset},
                    {eCh, eSl, eCtl, 13'd0, 16'(eOff)});
    if (eBm) check(bmChannel == eCh && bmOffset == 3'(eBmOff), tag, "bm route",
                   {bmChannel, bmOffset}, {eCh, 3'(eBmOff)});
    @(negedge clk);
    reqValid = 0;
    check(rspValid === 1'b1, {tag, " R11"}, "rspValid", 32'(rspValid), 1);
    check(rspDecErr == eErr, tag, "rspDecErr", 32'(rspDecErr), 32'(eErr));
    check(rspRdata == eRd, tag, "rspRdata", rspRdata, eRd);
    check(drvSelect == {selM[1][0], selM[0][0]}, tag, "drvSelect", 32'(drvSelect),
          32'({selM[1][0], selM[0][0]}));
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    winBase[0] = 16'h0100; winSize[0] = 16'd16;
    winBase[1] = 16'h0200; winSize[1] = 16'd4;
    winBase[2] = 16'h0300; winSize[2] = 16'd8;
    winBase[3] = 16'h0304; winSize[3] = 16'd8;
    winBase[4] = 16'h0400; winSize[4] = 16'd32;
    repeat (3) @(negedge clk);
    check(drvSelect == 2'b00 && rspValid == 0, "R4", "reset state", {drvSelect, rspValid}, 0);
    rstN = 1;
    @(negedge clk);
    check(rspValid == 0, "R4", "idle after reset", 32'(rspValid), 0);
    // R1: I/O disabled
    access("R1", 0, 'h106, 1, 0);
    access("R1", 1, 'h10C, 1, 32'h10);
    hostCmd = 16'h0005;
    // R8: offset adjust
    access("R8", 0, 'h106, 1, 0);
    access("R8", 0, 'h201, 2, 0);
    access("R8", 0, 'h30B, 1, 0);
    // R10: overlap of secondary windows
    access("R10", 0, 'h304, 1, 0);
    access("R10", 0, 'h308, 1, 0);
    // R3: select slave on primary, then back
    access("R3", 1, 'h10C, 1, 32'h10);
    access("R3", 0, 'h104, 1, 0);
    access("R3", 1, 'h10C, 1, 32'hEF);
    access("R3", 1, 'h10C, 1, 32'h10);
    // R5: secondary slave absent
    access("R5", 1, 'h306, 1, 32'h10);
    access("R5", 0, 'h302, 1, 0);
    access("R5", 0, 'h309, 1, 0);
    access("R5", 1, 'h301, 1, 32'h55);
    // R6: bus-master split
    access("R6", 0, 'h403, 1, 0);
    access("R6", 0, 'h40A, 2, 0);
    access("R6", 0, 'h412, 1, 0);
    // R2: bus-master write gating
    access("R2", 1, 'h409, 1, 32'h1);
    hostCmd = 16'h0001;
    access("R2", 1, 'h409, 1, 32'h1);
    access("R2", 0, 'h409, 1, 0);
    hostCmd = 16'h0005;
    // R9 and R7
    access("R9", 0, 'h900, 1, 0);
    access("R7", 0, 'h106, 3, 0);
    access("R7", 1, 'h10C, 0, 32'h00);
    access("R7", 0, 'h400, 4, 0);
    @(negedge clk);
    check(rspValid == 0, "R11", "no request no response", 32'(rspValid), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule